// File: doc/BRIEF.md
# Badline Fetch Sequencer

This block is the video controller's side of a bad line. On such a line the video chip takes the shared memory bus away from the processor and fetches one row of 12-bit character entries into a line buffer. Each entry is an 8-bit character pointer from video-matrix memory plus a 4-bit colour nibble from the separate colour memory.

The block advances only on cycles where the per-cycle strobe is high. When it sees the bad-line condition on such a cycle, it pulls the bus-available handshake low on the next cycle. The address-enable output keeps following the phase input for a fixed three strobe cycles and is then held low. During those three cycles the block issues no address. It stores an all-ones pointer and the processor bus's low nibble, as latched at takeover, so all three entries carry the same colour. The remaining entries come from a synchronous read port at the video-matrix base plus the column index. A decode flag marks which fetches land in the character-ROM windows.

Top module: `badline_fetch_seq`

## Requirements
- R1: When `bad_line` is high on a strobe cycle while the block is idle, `ba` is low from the next clock onward. `bad_line` has no effect while a takeover is already under way.
- R2: After `ba` falls, `aec` equals `phi2` for exactly three strobe cycles. After that it is held low until the row is done.
- R3: Buffer entries 0, 1 and 2 hold pointer bits [7:0] = 0xFF.
- R4: Colour bits [11:8] of entries 0 to 2 equal `cpu_bus_lo` as sampled on the strobe cycle that started the takeover. This holds even if the processor bus changes afterwards.
- R5: Entry k, for k from 3 to 39, is {`col_data`, `mem_data`}, sampled on the strobe edge while `mem_addr` = `vm_base` + k.
- R6: While a real fetch is being made, `mem_en` is high and both `ba` and `aec` are low.
- R7: `rom_sel` is high exactly when `mem_addr` lies in 0x1000–0x1FFF or 0x9000–0x9FFF, meaning address bits [14:12] = 001.
- R8: On the strobe cycle after entry 39 is written, `ba` returns high. `aec` stays low for one more strobe cycle and then follows `phi2` again.
- R9: Clocks with `cyc_stb` low change neither the state, the buffer nor the column index.
- R10: A synchronous active-high `rst` clears all 40 buffer entries and the column index, sets `ba` high and makes `aec` follow `phi2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One video cycle elapses on this clock |
| phi2 | input | 1 | Clock-phase indicator that `aec` tracks when not held |
| bad_line | input | 1 | Bad-line condition |
| cpu_bus_lo | input | 4 | Low nibble of the processor data bus |
| vm_base | input | 16 | Video-matrix base address |
| mem_addr | output | 16 | Fetch address (base plus column) |
| mem_en | output | 1 | A real pointer/colour fetch is in progress |
| rom_sel | output | 1 | Fetch address decodes to character ROM |
| mem_data | input | 8 | Video-matrix read data for `mem_addr` |
| col_data | input | 4 | Colour memory read data for `mem_addr` |
| ba | output | 1 | Bus available, low while the bus is taken |
| aec | output | 1 | Address enable |
| rd_idx | input | 6 | Line-buffer read index |
| rd_entry | output | 12 | Line-buffer entry {colour, pointer} |

## Verification
The hardest case to reach is the three-cycle stall window. Its colour must come from a nibble latched at the takeover strobe, not from the live bus. It is also easy to misplace by one cycle when strobes are gapped. The stimulus switches `cpu_bus_lo` to its complement right after takeover and drops strobes at random during whole rows. A reference model compares `ba`, `aec`, `mem_en`, the address and the ROM flag on every clock. The rows start at bases that cross into both ROM windows, and `bad_line` is held high through a row to show that it is ignored there.

// File: rtl/badline_fetch_seq.sv
module badline_fetch_seq #(
  parameter int ADDR_W = 16,
  parameter int NCOL   = 40,
  parameter int CNT_W  = 10,
  parameter int PTR_W  = 8,
  parameter int COL_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cyc_stb,
  input  logic                       phi2,
  input  logic                       bad_line,
  input  logic [COL_W-1:0]           cpu_bus_lo,
  input  logic [ADDR_W-1:0]          vm_base,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_en,
  output logic                       rom_sel,
  input  logic [PTR_W-1:0]           mem_data,
  input  logic [COL_W-1:0]           col_data,
  output logic                       ba,
  output logic                       aec,
  input  logic [$clog2(NCOL)-1:0]    rd_idx,
  output logic [PTR_W+COL_W-1:0]     rd_entry
);
  localparam int IDX_W   = $clog2(NCOL);
  localparam int ENT_W   = PTR_W + COL_W;
  localparam int STALL_N = 3;

  typedef enum logic [1:0] {S_IDLE, S_STALL, S_FETCH, S_REL} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] col_q;
  logic [COL_W-1:0] nib_q;
  logic [ENT_W-1:0] buf_q [NCOL];

  logic             wr_en;
  logic [ENT_W-1:0] wr_data;

  assign ba       = (st_q == S_IDLE) || (st_q == S_REL);
  assign aec      = (st_q == S_IDLE || st_q == S_STALL) ? phi2 : 1'b0;
  assign mem_en   = (st_q == S_FETCH);
  assign mem_addr = vm_base + ADDR_W'(col_q);
  assign rom_sel  = (mem_addr[ADDR_W-2:ADDR_W-4] == 3'b001);
  assign wr_en    = cyc_stb && (st_q == S_STALL || st_q == S_FETCH);
  assign wr_data  = (st_q == S_STALL) ? {nib_q, {PTR_W{1'b1}}} : {col_data, mem_data};
  assign rd_entry = (int'(rd_idx) < NCOL) ? buf_q[rd_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      col_q <= '0;
      nib_q <= '0;
      for (int i = 0; i < NCOL; i++) buf_q[i] <= '0;
    end else begin
      if (wr_en) buf_q[col_q[IDX_W-1:0]] <= wr_data;
      if (cyc_stb) begin
        case (st_q)
          S_IDLE: if (bad_line) begin
            st_q  <= S_STALL;
            col_q <= '0;
            nib_q <= cpu_bus_lo;
          end
          S_STALL: begin
            col_q <= col_q + 1'b1;
            if (col_q == CNT_W'(STALL_N - 1)) st_q <= S_FETCH;
          end
          S_FETCH: begin
            if (col_q == CNT_W'(NCOL - 1)) begin
              st_q  <= S_REL;
              col_q <= '0;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  ba_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ba && !mem_en && !$stable(1'b0) || (cyc_stb && bad_line && ba && aec == phi2 && st_q == S_IDLE)) |=> !ba);
  // R2
  stall_aec_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ba) |-> (aec == phi2));
  // R6
  fetch_bus_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (!ba && !aec));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ba) |-> !aec);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cyc_stb && !ba) |=> !ba);
endmodule

// File: tb/badline_fetch_seq_tb.sv
module badline_fetch_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_stb = 1'b0;
  logic        phi2 = 1'b0;
  logic        bad_line = 1'b0;
  logic [3:0]  cpu_bus_lo = 4'h0;
  logic [15:0] vm_base = 16'h0400;
  logic [15:0] mem_addr;
  logic        mem_en, rom_sel, ba, aec;
  logic [7:0]  mem_data;
  logic [3:0]  col_data;
  logic [5:0]  rd_idx = 6'd0;
  logic [11:0] rd_entry;

  int checks = 0;
  int fails  = 0;
  bit gapped = 1'b0;

  int m_st = 0;
  int m_col = 0;
  int m_nib = 0;
  int m_buf [40];

  always #10 clk = ~clk;

  function automatic bit in_rom(input int a);
    return ((a >= 16'h1000 && a <= 16'h1FFF) || (a >= 16'h9000 && a <= 16'h9FFF));
  endfunction
  function automatic int memf(input int a);
    if (in_rom(a)) return (a * 7 + 3) & 8'hFF;
    return ((a ^ (a >> 8)) * 13 + 5) & 8'hFF;
  endfunction
  function automatic int colf(input int a);
    return (a * 5 + 1) & 4'hF;
  endfunction

  assign mem_data = memf(int'(mem_addr))[7:0];
  assign col_data = colf(int'(mem_addr))[3:0];

  badline_fetch_seq u_dut (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .phi2(phi2), .bad_line(bad_line),
    .cpu_bus_lo(cpu_bus_lo), .vm_base(vm_base), .mem_addr(mem_addr), .mem_en(mem_en),
    .rom_sel(rom_sel), .mem_data(mem_data), .col_data(col_data), .ba(ba), .aec(aec),
    .rd_idx(rd_idx), .rd_entry(rd_entry));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    phi2    <= 1'($urandom);
    cyc_stb <= gapped ? ($urandom % 3 != 0) : 1'b1;
  end

  // reference model and per-clock comparison
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_col = 0; m_nib = 0;
      foreach (m_buf[i]) m_buf[i] = 0;
    end else if (cyc_stb) begin
      case (m_st)
        0: if (bad_line) begin m_st = 1; m_col = 0; m_nib = cpu_bus_lo; end
        1: begin
          m_buf[m_col] = (m_nib << 8) | 8'hFF;
          if (m_col == 2) m_st = 2;
          m_col++;
        end
        2: begin
          m_buf[m_col] = (colf((vm_base + m_col) & 16'hFFFF) << 8) | memf((vm_base + m_col) & 16'hFFFF);
          if (m_col == 39) begin m_st = 3; m_col = 0; end else m_col++;
        end
        default: m_st = 0;
      endcase
    end
    #5;
    if (!rst) begin
      chk("R1 R8 ba", ba, (m_st == 0 || m_st == 3));
      chk("R2 R8 R9 aec", aec, (m_st <= 1) ? phi2 : 0);
      chk("R6 mem_en", mem_en, m_st == 2);
      if (m_st == 2) begin
        chk("R5 mem_addr", mem_addr, (vm_base + m_col) & 16'hFFFF);
        chk("R7 rom_sel", rom_sel, in_rom((vm_base + m_col) & 16'hFFFF));
      end
    end
  end

  task automatic readback(input string tag);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rd_idx = 6'(i);
      #2;
      chk(tag, rd_entry, m_buf[i]);
    end
  endtask

  task automatic run_line(input logic [15:0] base, input logic [3:0] op, input bit hold_bl);
    int guard = 0;
    @(negedge clk);
    vm_base = base;
    cpu_bus_lo = op;
    bad_line = 1'b1;
    while (m_st == 0 && guard < 100) begin @(negedge clk); guard++; end
    cpu_bus_lo = ~op;
    if (!hold_bl) bad_line = 1'b0;
    while (m_st != 3 && guard < 2000) begin @(negedge clk); guard++; end
    bad_line = 1'b0;
    while (m_st != 0 && guard < 2100) begin @(negedge clk); guard++; end
    readback("R3/R4/R5 entry");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    readback("R10 reset entry");
    run_line(16'h0400, 4'h7, 1'b0);
    gapped = 1'b1;
    run_line(16'h0FE8, 4'hA, 1'b1);
    run_line(16'h9FF0, 4'h3, 1'b0);
    gapped = 1'b0;
    run_line(16'hFFF0, 4'hE, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    readback("R10 cleared entry");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule